// File: doc/BRIEF.md
# Copy-Protection Component Persistence Detector

This block decides whether two analog copy-protection components are present on incoming video: colour stripes and extra pseudo sync pulses. An upstream analog front end supplies single-cycle indications: one when a stripe burst is seen on a line, and one for each extra pseudo sync pulse. A single-cycle strobe marks the end of each field. At every strobe the block turns the indications gathered during that field into a qualified or unqualified result for each component.

A component's status bit changes only after the opposite result has held for a programmable number of consecutive fields. That count is the programmed value plus two, and it applies to both setting and clearing. A control byte holds the enable bits, the pulse threshold and the persistence count. The stripe status, gated by its enable, drives a bypass enable for the downstream stripe correction.

All pins are plain level or strobe signals. The indications are events rather than a data stream, so there is no valid/ready handshake and no back-pressure. An indication is counted in the cycle in which it is high.

Top module: `cp_persist_detect`

## Requirements
- R1: During and after reset, `stripe_status`, `psp_status` and `stripe_bypass` are 0.
- R2: The control byte is decoded as follows: bit 7 is the stripe enable, bit 6 the pseudo sync enable, bits 5:3 the pulse threshold T, and bits 2:0 the persistence setting P. The number of fields required is N = P + 2, so the setting 6 requires 8 fields.
- R3: A field qualifies for stripes if `stripe_hit` was high in at least one cycle from the previous strobe (exclusive) up to and including the strobe cycle.
- R4: A field qualifies for pseudo sync if the number of cycles with `psp_hit` high over the same span is at least T. With T = 0, every field qualifies.
- R5: With its enable set, a status that is 0 becomes 1 in the cycle after the strobe that closes the N-th consecutive qualifying field.
- R6: With its enable set, a status that is 1 becomes 0 in the cycle after the strobe that closes the N-th consecutive non-qualifying field.
- R7: A field whose result equals the current status restarts the run of opposite fields from zero.
- R8: While a component's enable is 0, its status holds and its run counter is cleared. Fields are still closed at each strobe, but they have no effect on the status.
- R9: `stripe_bypass` is 1 exactly when the stripe enable is 1 and `stripe_status` is 1.
- R10: A status bit changes only in the cycle after a cycle in which `field_stb` is high.
- R11: The per-field pulse count saturates instead of wrapping, so 16 pulses still meet T = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 8 | Control byte (enables, threshold, persistence) |
| field_stb | input | 1 | One-cycle end-of-field strobe |
| stripe_hit | input | 1 | Stripe burst seen in this cycle |
| psp_hit | input | 1 | One extra pseudo sync pulse seen in this cycle |
| stripe_status | output | 1 | Stripe component declared present |
| psp_status | output | 1 | Pseudo sync component declared present |
| stripe_bypass | output | 1 | Enable for stripe correction bypass |

## Verification
The hardest state to reach is a run counter left partly advanced at the moment its enable drops. Showing that the count is discarded requires a specific sequence on the stripe component. The bench first sets the status, then closes one opposite field, disables the component and strobes more fields. It then re-enables the component and shows that one further opposite field is not enough to flip the status. Pulse-count saturation is reached with a field carrying exactly one more pulse than the counter's wrap point.

// File: rtl/cp_persist_pkg.sv
package cp_persist_pkg;
  typedef struct packed {
    logic       stripe_en;
    logic       psp_en;
    logic [2:0] psp_thr;
    logic [2:0] persist;
  } cp_ctrl_t;

  localparam int unsigned NUM_COMP   = 2;
  localparam int unsigned COMP_STRIPE = 0;
  localparam int unsigned COMP_PSP    = 1;

  function automatic cp_ctrl_t cp_decode(input logic [7:0] raw);
    cp_ctrl_t c;
    c.stripe_en = raw[7];
    c.psp_en    = raw[6];
    c.psp_thr   = raw[5:3];
    c.persist   = raw[2:0];
    return c;
  endfunction
endpackage

// File: rtl/cp_field_accum.sv
module cp_field_accum #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             hit,
  input  logic [THR_W-1:0] thr,
  output logic             qual
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] total;

  // Count for the closing field, including a hit in the strobe cycle.
  always_comb begin
    if (hit && cnt != CNT_MAX) total = cnt + 1'b1;
    else                       total = cnt;
    qual = ({{(32-CNT_W){1'b0}}, total} >= {{(32-THR_W){1'b0}}, thr});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (stb)                    cnt <= '0;
    else if (hit && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cp_persist_filter.sv
module cp_persist_filter #(
  parameter int unsigned RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic             qual,
  input  logic [RUN_W-1:0] need,
  output logic             status
);
  logic [RUN_W-1:0] run;
  logic [RUN_W:0]   run_next;

  assign run_next = {1'b0, run} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      status <= 1'b0;
    end else if (!en) begin
      run <= '0;
    end else if (stb) begin
      if (qual == status) begin
        run <= '0;
      end else if (run_next >= {1'b0, need}) begin
        status <= qual;
        run    <= '0;
      end else begin
        run <= run_next[RUN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cp_persist_detect.sv
module cp_persist_detect
  import cp_persist_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned THR_W     = 3,
  parameter int unsigned PERSIST_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl,
  input  logic       field_stb,
  input  logic       stripe_hit,
  input  logic       psp_hit,
  output logic       stripe_status,
  output logic       psp_status,
  output logic       stripe_bypass
);
  localparam int unsigned RUN_W   = PERSIST_W + 1;
  localparam int unsigned NEED_OFS = 2;

  cp_ctrl_t          cfg;
  logic [RUN_W-1:0]  need;
  logic [NUM_COMP-1:0] hit_v, en_v, qual_v, stat_v;
  logic [THR_W-1:0]  thr_v [NUM_COMP];

  assign cfg  = cp_decode(ctrl);
  assign need = RUN_W'({1'b0, cfg.persist}) + RUN_W'(NEED_OFS);

  assign hit_v[COMP_STRIPE] = stripe_hit;
  assign hit_v[COMP_PSP]    = psp_hit;
  assign en_v[COMP_STRIPE]  = cfg.stripe_en;
  assign en_v[COMP_PSP]     = cfg.psp_en;
  assign thr_v[COMP_STRIPE] = THR_W'(1);
  assign thr_v[COMP_PSP]    = THR_W'(cfg.psp_thr);

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    cp_field_accum #(.CNT_W(CNT_W), .THR_W(THR_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (field_stb),
      .hit  (hit_v[k]),
      .thr  (thr_v[k]),
      .qual (qual_v[k])
    );
    cp_persist_filter #(.RUN_W(RUN_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (field_stb),
      .en    (en_v[k]),
      .qual  (qual_v[k]),
      .need  (need),
      .status(stat_v[k])
    );
  end

  assign stripe_status = stat_v[COMP_STRIPE];
  assign psp_status    = stat_v[COMP_PSP];
  assign stripe_bypass = cfg.stripe_en & stat_v[COMP_STRIPE];
endmodule

// File: rtl/cp_persist_chk.sv
module cp_persist_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic       field_stb,
  input logic       stripe_hit,
  input logic       psp_hit,
  input logic       stripe_status,
  input logic       psp_status,
  input logic       stripe_bypass
);
  logic       s_prev, p_prev;
  logic [3:0] s_sc, p_sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0; p_prev <= 1'b0; s_sc <= '0; p_sc <= '0;
    end else begin
      s_prev <= stripe_status;
      p_prev <= psp_status;
      if (stripe_status != s_prev)           s_sc <= field_stb ? 4'd1 : 4'd0;
      else if (field_stb && s_sc != 4'd15)   s_sc <= s_sc + 4'd1;
      if (psp_status != p_prev)              p_sc <= field_stb ? 4'd1 : 4'd0;
      else if (field_stb && p_sc != 4'd15)   p_sc <= p_sc + 4'd1;
    end
  end

  always @(negedge clk)
    if (!rst_n)
      a_r1_reset_clear: assert (!stripe_status && !psp_status && !stripe_bypass);

  a_r10_stripe_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> $stable(stripe_status));
  a_r10_psp_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> $stable(psp_status));
  a_r8_stripe_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[7] |=> $stable(stripe_status));
  a_r8_psp_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |=> $stable(psp_status));
  a_r9_bypass_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_bypass |-> ctrl[7]);
  a_r5_stripe_min_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stripe_status != s_prev) |-> (s_sc >= 4'd2));
  a_r6_psp_min_run: assert property (@(posedge clk) disable iff (!rst_n)
    (psp_status != p_prev) |-> (p_sc >= 4'd2));
endmodule

bind cp_persist_detect cp_persist_chk u_chk (.*);

// File: tb/sim_cp_persist_detect.sv
module sim_cp_persist_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       field_stb = 1'b0;
  logic       stripe_hit = 1'b0;
  logic       psp_hit = 1'b0;
  logic       stripe_status, psp_status, stripe_bypass;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cp_persist_detect u0 (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .field_stb(field_stb),
    .stripe_hit(stripe_hit), .psp_hit(psp_hit),
    .stripe_status(stripe_status), .psp_status(psp_status),
    .stripe_bypass(stripe_bypass)
  );

  function automatic logic [7:0] mk(input logic se, input logic pe,
                                    input int thr, input int p);
    return {se, pe, 3'(thr), 3'(p)};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one field: hits on leading cycles, then the strobe cycle.
  task automatic field(input int ns, input int np, input logic on_stb);
    int len;
    len = (ns > np) ? ns : np;
    for (int i = 0; i < len; i++) begin
      stripe_hit = (i < ns);
      psp_hit    = (i < np);
      @(negedge clk);
    end
    stripe_hit = on_stb;
    psp_hit    = on_stb;
    field_stb  = 1'b1;
    @(negedge clk);
    field_stb  = 1'b0;
    stripe_hit = 1'b0;
    psp_hit    = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 stripe_status", stripe_status, 1'b0);
    check("R1 psp_status", psp_status, 1'b0);
    check("R1 stripe_bypass", stripe_bypass, 1'b0);
  endtask

  task automatic t_stripe_set();
    ctrl = mk(1, 0, 0, 0);
    field(1, 0, 0);
    check("R5 one field not enough", stripe_status, 1'b0);
    stripe_hit = 1'b1;
    @(negedge clk);
    stripe_hit = 1'b0;
    @(negedge clk);
    check("R10 no change mid-field", stripe_status, 1'b0);
    field(0, 0, 0);
    check("R5 set after N=2 fields", stripe_status, 1'b1);
    check("R9 bypass on", stripe_bypass, 1'b1);
  endtask

  task automatic t_stripe_clear();
    field(0, 0, 0);
    check("R6 one empty field holds", stripe_status, 1'b1);
    field(0, 0, 0);
    check("R6 cleared after 2 empty", stripe_status, 1'b0);
    check("R9 bypass off", stripe_bypass, 1'b0);
  endtask

  task automatic t_run_reset();
    ctrl = mk(1, 0, 0, 1);
    field(1, 0, 0); field(1, 0, 0); field(0, 0, 0);
    field(1, 0, 0); field(1, 0, 0);
    check("R7 run restarted", stripe_status, 1'b0);
    field(1, 0, 0);
    check("R7 set after 3 in a row", stripe_status, 1'b1);
  endtask

  task automatic t_default_count();
    ctrl = mk(1, 0, 0, 6);
    for (int i = 0; i < 7; i++) field(0, 0, 0);
    check("R2 7 fields hold at P=6", stripe_status, 1'b1);
    field(0, 0, 0);
    check("R2 cleared at 8th field", stripe_status, 1'b0);
  endtask

  task automatic t_strobe_hit();
    ctrl = mk(1, 0, 0, 0);
    field(0, 0, 1);
    field(0, 0, 1);
    check("R3 hit on strobe cycle counts", stripe_status, 1'b1);
  endtask

  task automatic t_disable();
    field(0, 0, 0);
    check("R8 run at 1 holds", stripe_status, 1'b1);
    ctrl = mk(0, 0, 0, 0);
    @(negedge clk);
    check("R9 bypass off when disabled", stripe_bypass, 1'b0);
    for (int i = 0; i < 3; i++) field(0, 0, 0);
    check("R8 held while disabled", stripe_status, 1'b1);
    ctrl = mk(1, 0, 0, 0);
    @(negedge clk);
    check("R9 bypass back on", stripe_bypass, 1'b1);
    field(0, 0, 0);
    check("R8 run cleared by disable", stripe_status, 1'b1);
    field(0, 0, 0);
    check("R8 clears after re-enable", stripe_status, 1'b0);
  endtask

  task automatic t_psp_thr();
    ctrl = mk(0, 1, 3, 0);
    field(0, 2, 0); field(0, 2, 0);
    check("R4 below threshold", psp_status, 1'b0);
    field(0, 3, 0);
    check("R4 one field at threshold", psp_status, 1'b0);
    field(0, 3, 0);
    check("R4 set at threshold", psp_status, 1'b1);
    check("R8 stripe unaffected while off", stripe_status, 1'b0);
    field(0, 0, 0); field(0, 0, 0);
    check("R6 psp cleared", psp_status, 1'b0);
    ctrl = mk(0, 1, 0, 0);
    field(0, 0, 0); field(0, 0, 0);
    check("R4 T=0 always qualifies", psp_status, 1'b1);
    ctrl = mk(0, 1, 1, 0);
    field(0, 0, 0); field(0, 0, 0);
    check("R6 psp cleared T=1", psp_status, 1'b0);
  endtask

  task automatic t_saturate();
    ctrl = mk(0, 1, 1, 0);
    field(0, 16, 0);
    check("R11 one field holds", psp_status, 1'b0);
    field(0, 16, 0);
    check("R11 16 pulses meet T=1", psp_status, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stripe_set();
    t_stripe_clear();
    t_run_reset();
    t_default_count();
    t_strobe_hit();
    t_disable();
    t_psp_thr();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule